// File: doc/BRIEF.md
# Ring-Counter Accumulator Test Pattern Generator

This block generates a stream of 8-bit test vectors for a small datapath under test, such as a multiplier that takes two 4-bit operands. A one-hot word rotates through a ring register by one position on each enabled clock. That word is staged for one cycle in a holding register. It is then added into an accumulator, and the accumulator is the pattern output.

The adder in the accumulation path is a carry-select adder. Its blocks are a parameter, four bits each by default. The pattern is also offered already split into a low and a high operand nibble, so it can be wired straight to a two-operand unit. A valid flag tells the consumer when the accumulator first holds a loaded value.

The generator advances only on cycles where `en` is high. A synchronous `clr` restarts the sequence from its reset state, and `clr` takes priority over `en`. The asynchronous active-low reset is released to the internal logic through a two-stage synchronizer.

Top module: `tpg_ring_accum`

## Requirements
- R1: While reset is asserted, and until the first enabled step after reset, `pattern` is 0 and `pat_valid` is 0.
- R2: The ring word starts at 8'b0000_0001 and rotates left by one bit on every enabled cycle. It is therefore always one-hot, and after the k-th enabled step (k>=2) the pattern grows by exactly 1<<((k-2) mod 8).
- R3: The first enabled step only loads the staging register, so `pattern` stays 0 and `pat_valid` stays 0.
- R4: On the second enabled step the accumulator takes the first staged word, so `pattern` becomes 8'h01 and `pat_valid` rises in the same cycle.
- R5: The accumulator adds the staged word modulo 256 and discards the carry out. After 9 enabled steps the pattern is 8'hFF, and after 10 it is 8'h00.
- R6: The carry-select adder returns (x+y) mod 256 for every pair of 8-bit operands.
- R7: A cycle with `en` low and `clr` low leaves `pattern` and `pat_valid` unchanged, and it does not advance the sequence.
- R8: `clr` high at a rising edge returns the ring, staging and accumulator registers to their reset state, whatever `en` is. The sequence then restarts exactly as after reset.
- R9: `op_lo` equals `pattern[3:0]` and `op_hi` equals `pattern[7:4]`.
- R10: Once `pat_valid` is high, it stays high until `clr` or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Advance the generator by one step |
| clr | input | 1 | Synchronous restart, has priority over en |
| pattern | output | 8 | Current accumulator value (test vector) |
| op_lo | output | 4 | Low operand nibble of the pattern |
| op_hi | output | 4 | High operand nibble of the pattern |
| pat_valid | output | 1 | Accumulator holds a loaded value |

## Verification
Every registered result changes at the rising edge at which its stimulus is sampled. `pattern` reflects a step one edge after `en`. The first non-zero vector appears only at the second enabled edge, because the staging register adds a cycle of latency. Internal reset release takes two rising edges after `rst_n` goes high. The bench therefore drives `en` and `clr` on falling edges and samples 1 ns after the following rising edge. It compares each sample with a step count kept arithmetically in the bench. The adder is swept exhaustively as a stand-alone combinational instance.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  // Default geometry of the generator.
  localparam int unsigned PAT_W = 8;
  localparam int unsigned CSA_BLK = 4;
  localparam int unsigned OPND_W = PAT_W / 2;
endpackage

// File: rtl/tpg_rst_sync.sv
module tpg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/tpg_ring.sv
module tpg_ring #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         clr,
  output logic [W-1:0] word
);
  localparam logic [W-1:0] SEED = W'(1);

  logic [W-1:0] word_q;
  logic [W-1:0] word_d;

  // Next state: clear wins, otherwise rotate left by one on a step.
  always_comb begin
    word_d = word_q;
    if (clr) begin
      word_d = SEED;
    end else if (step) begin
      word_d = {word_q[W-2:0], word_q[W-1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= SEED;
    end else begin
      word_q <= word_d;
    end
  end

  assign word = word_q;

  // R2: the ring always holds exactly one set bit.
  a_r2_ring_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(word_q) == 1);

  // R2: a step moves the set bit one place up, wrapping at the top.
  a_r2_ring_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr) |=> (word_q == {$past(word_q[W-2:0]), $past(word_q[W-1])}));

  // R8: clear restores the seed word.
  a_r8_ring_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (word_q == SEED));

  // R7: an idle cycle leaves the ring untouched.
  a_r7_ring_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(word_q));
endmodule

// File: rtl/tpg_csa_add.sv
module tpg_csa_add #(
  parameter int unsigned W   = 8,
  parameter int unsigned BLK = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] sum
);
  localparam int unsigned NBLK = W / BLK;

  // carry[b] is the carry into block b (b >= 1).
  logic [NBLK-1:1] carry;

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    logic [BLK-1:0] xs;
    logic [BLK-1:0] ys;
    assign xs = x[b*BLK +: BLK];
    assign ys = y[b*BLK +: BLK];

    if (b == 0) begin : g_first
      // Lowest block: single ripple sum with carry-in zero.
      logic [BLK:0] r0;
      assign r0 = {1'b0, xs} + {1'b0, ys};
      assign sum[b*BLK +: BLK] = r0[BLK-1:0];
      assign carry[b+1] = r0[BLK];
    end else if (b == NBLK - 1) begin : g_last
      // Top block: carry out is discarded, so only BLK-wide sums.
      logic [BLK-1:0] s0;
      logic [BLK-1:0] s1;
      assign s0 = xs + ys;
      assign s1 = xs + ys + BLK'(1);
      assign sum[b*BLK +: BLK] = carry[b] ? s1 : s0;
    end else begin : g_mid
      // Middle block: both carry-in cases, selected by the lower carry.
      logic [BLK:0] r0;
      logic [BLK:0] r1;
      assign r0 = {1'b0, xs} + {1'b0, ys};
      assign r1 = {1'b0, xs} + {1'b0, ys} + (BLK+1)'(1);
      assign sum[b*BLK +: BLK] = carry[b] ? r1[BLK-1:0] : r0[BLK-1:0];
      assign carry[b+1] = carry[b] ? r1[BLK] : r0[BLK];
    end
  end

  // R6: the selected result matches a plain modular sum.
  always_comb begin
    a_r6_csa_sum: assert (sum == (x + y));
  end
endmodule

// File: rtl/tpg_accum.sv
module tpg_accum #(
  parameter int unsigned W   = 8,
  parameter int unsigned BLK = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         clr,
  input  logic [W-1:0] ring_word,
  output logic [W-1:0] acc,
  output logic         valid
);
  logic [W-1:0] stage_q, stage_d;
  logic [W-1:0] acc_q, acc_d;
  logic         loaded_q, loaded_d;
  logic         valid_q, valid_d;
  logic [W-1:0] add_res;

  tpg_csa_add #(.W(W), .BLK(BLK)) u_add (
    .x   (acc_q),
    .y   (stage_q),
    .sum (add_res)
  );

  // Next state: stage the ring word and fold the previous stage into acc.
  always_comb begin
    stage_d  = stage_q;
    acc_d    = acc_q;
    loaded_d = loaded_q;
    valid_d  = valid_q;
    if (clr) begin
      stage_d  = '0;
      acc_d    = '0;
      loaded_d = 1'b0;
      valid_d  = 1'b0;
    end else if (step) begin
      stage_d  = ring_word;
      acc_d    = add_res;
      loaded_d = 1'b1;
      valid_d  = valid_q | loaded_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      acc_q    <= '0;
      loaded_q <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      stage_q  <= stage_d;
      acc_q    <= acc_d;
      loaded_q <= loaded_d;
      valid_q  <= valid_d;
    end
  end

  assign acc   = acc_q;
  assign valid = valid_q;

  // R3: nothing has reached the accumulator before the stage is loaded.
  a_r3_empty_until_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded_q |-> (acc_q == '0 && !valid_q));

  // R5: a step adds the staged word, wrapping modulo 2**W.
  a_r5_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr) |=> (acc_q == W'($past(acc_q) + $past(stage_q))));

  // R4: valid rises only on a step taken with the stage already loaded.
  a_r4_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> ($past(loaded_q) && $past(step)));

  // R7: idle cycles hold the outputs.
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> ($stable(acc_q) && $stable(valid_q)));

  // R8: clear empties the accumulator and drops valid.
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0 && !valid_q && stage_q == '0));

  // R10: valid is sticky until clear.
  a_r10_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !clr) |=> valid_q);
endmodule

// File: rtl/tpg_ring_accum.sv
module tpg_ring_accum
  import tpg_pkg::*;
#(
  parameter int unsigned W   = PAT_W,
  parameter int unsigned BLK = CSA_BLK
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           clr,
  output logic [W-1:0]   pattern,
  output logic [W/2-1:0] op_lo,
  output logic [W/2-1:0] op_hi,
  output logic           pat_valid
);
  localparam int unsigned HALF = W / 2;

  logic         rst_n_int;
  logic [W-1:0] ring_word;

  tpg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  tpg_ring #(.W(W)) u_ring (
    .clk   (clk),
    .rst_n (rst_n_int),
    .step  (en),
    .clr   (clr),
    .word  (ring_word)
  );

  tpg_accum #(.W(W), .BLK(BLK)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .step      (en),
    .clr       (clr),
    .ring_word (ring_word),
    .acc       (pattern),
    .valid     (pat_valid)
  );

  assign op_lo = pattern[HALF-1:0];
  assign op_hi = pattern[W-1:HALF];

  // R9: the operand halves tile the pattern.
  a_r9_split: assert property (@(posedge clk) disable iff (!rst_n_int)
    {op_hi, op_lo} == pattern);

  // R1: during internal reset the outputs are quiet.
  always_comb begin
    if (!rst_n_int) begin
      a_r1_reset_quiet: assert (pattern == '0 && !pat_valid);
    end
  end
endmodule

// File: tb/tb_tpg_ring_accum.sv
`timescale 1ns/1ps
module tb_tpg_ring_accum;
  logic       clk;
  logic       rst_n;
  logic       en;
  logic       clr;
  logic [7:0] pattern;
  logic [3:0] op_lo;
  logic [3:0] op_hi;
  logic       pat_valid;

  logic [7:0] ax, ay, asum;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  int         k_steps = 0;
  logic [7:0] exp_pat = 8'h00;

  tpg_ring_accum dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .clr       (clr),
    .pattern   (pattern),
    .op_lo     (op_lo),
    .op_hi     (op_hi),
    .pat_valid (pat_valid)
  );

  tpg_csa_add #(.W(8), .BLK(4)) u_csa_iso (
    .x   (ax),
    .y   (ay),
    .sum (asum)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Compare every output against the bench model.
  task automatic check_all(input string req);
    bit ev;
    ev = (k_steps >= 2);
    chk(pattern == exp_pat, req, int'(pattern), int'(exp_pat));
    chk(pat_valid == ev, {req, " valid"}, int'(pat_valid), int'(ev));
    chk(op_lo == exp_pat[3:0] && op_hi == exp_pat[7:4], "R9 operand split",
        int'({op_hi, op_lo}), int'(exp_pat));
  endtask

  // Drive at the falling edge, sample 1 ns after the rising edge.
  task automatic do_step(input logic e, input logic c, input string req);
    @(negedge clk);
    en  = e;
    clr = c;
    @(posedge clk);
    #1;
    if (c) begin
      k_steps = 0;
      exp_pat = 8'h00;
    end else if (e) begin
      if (k_steps >= 1) exp_pat = exp_pat + 8'(1 << ((k_steps - 1) % 8));
      k_steps++;
    end
    check_all(req);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    en    = 1'b0;
    clr   = 1'b0;
    ax    = 8'h00;
    ay    = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) begin
      do_step(1'b0, 1'b0, "R1 after release");
    end

    do_step(1'b1, 1'b0, "R3 first step");
    do_step(1'b1, 1'b0, "R4 second step");
    for (int i = 3; i <= 9; i++) begin
      do_step(1'b1, 1'b0, "R2 accumulate");
    end
    chk(pattern == 8'hFF, "R5 full ring sum", int'(pattern), 8'hFF);
    do_step(1'b1, 1'b0, "R5 wrap");
    chk(pattern == 8'h00, "R5 wrap to zero", int'(pattern), 8'h00);
    chk(pat_valid == 1'b1, "R10 valid after wrap", int'(pat_valid), 1);

    for (int i = 0; i < 60; i++) begin
      if (i % 3 == 2) do_step(1'b0, 1'b0, "R7 idle hold");
      else            do_step(1'b1, 1'b0, "R2 R10 mixed steps");
    end

    do_step(1'b1, 1'b1, "R8 clear with en");
    do_step(1'b1, 1'b0, "R8 restart first");
    do_step(1'b1, 1'b0, "R8 restart second");
    do_step(1'b1, 1'b0, "R8 restart third");
    do_step(1'b0, 1'b1, "R8 clear without en");
    do_step(1'b0, 1'b0, "R7 idle after clear");
    for (int i = 0; i < 20; i++) begin
      do_step(1'b1, 1'b0, "R2 second run");
    end

    // R6: exhaustive sweep of the isolated adder.
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        logic [7:0] want;
        ax = 8'(i);
        ay = 8'(j);
        #1;
        want = 8'(i + j);
        chk(asum == want, "R6 csa sum", int'(asum), int'(want));
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule